// File: doc/BRIEF.md
# Indirect PLL Tuning Register Bridge

This block is a memory-mapped control slave with a 7-bit word address and a 16-bit data path. It gives software indirect access to the tuning registers of a group of transmit PLLs. Software loads three registers: a logical channel number, a back-end offset and a data word. It then sets a trigger bit in the control register to start a read or a write. The bridge looks up the logical channel in a mapping table held as a parameter. If the table holds a PLL for that channel, the bridge runs one request/acknowledge transfer on a small back-end register bus to that PLL's port. If it does not, the bridge flags an error and leaves the bus idle.

A write to back-end offset 0 with data bit 1 set is treated as a calibration trigger and is not a bus transfer. The bridge sends a one-cycle start pulse to the selected PLL's tuning engine and waits for a done or fail report. When the calibration ends, the trigger bit in the data word clears itself. A calibration that fails to converge raises the same error flag as an unconnected channel. A busy flag in the control register covers every operation from start to end.

Top module: `pll_tune_bridge`

## Requirements
- R1: After reset, the channel, offset and data registers, the busy and error flags, `be_req` and `cal_start` are all 0.
- R2: Address 0x30 holds a 10-bit channel number, 0x33 a 4-bit offset and 0x34 a 16-bit data word, each readable and writable. Bits above each field read 0. Address 0x32 reads error in bit 9, busy in bit 8 and 0 elsewhere. Every other address reads 0. Read data appears on `csr_rdata` the cycle after `csr_rd`.
- R3: Writing 0x32 with bit 0 set starts an indirect write. In the next cycle, `be_req` is 1, `be_we` is 1, `pll_sel` holds the mapped port, `be_ofs` holds the offset register and `be_wdata` holds the data register. These stay stable until `be_ack` is sampled high.
- R4: Writing 0x32 with bit 1 set (and bit 0 clear) starts an indirect read with `be_we` = 0. The value on `be_rdata` in the cycle `be_ack` is high is loaded into the data register.
- R5: Busy reads 1 from the cycle after an accepted command until the edge that samples `be_ack`, `cal_done` or `cal_fail`. It reads 0 from the cycle after that edge.
- R6: A command whose channel has its valid bit clear, or whose channel number is equal to or above the table size, sets error in the next cycle. It raises neither `be_req` nor `cal_start`, and busy stays 0.
- R7: An indirect write to offset 0 with data bit 1 set is a calibration. It gives a single-cycle `cal_start` with `pll_sel` set to the mapped port, and no `be_req`. It ends on `cal_done` or `cal_fail`, and at the end data bit 1 clears while the other data bits keep their value.
- R8: A calibration that ends with `cal_fail` sets error. One that ends with `cal_done` leaves error at 0.
- R9: Error clears to 0 when the next command is accepted.
- R10: While busy is 1, new commands and writes to 0x30, 0x33 and 0x34 are ignored.
- R11: A control write with both bit 0 and bit 1 set is treated as a write.
- R12: In the default table, logical channels 0, 1, 2 and 4 map to ports 2, 0, 3 and 1. Channels 3 and 5 are unconnected. Each entry is {valid, port}, with channel i at bits [3i+2:3i].
- R13: An indirect write to offset 0 with data bit 1 clear is an ordinary back-end write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 7 | Front-end word address |
| csr_wr | input | 1 | Front-end write strobe |
| csr_wdata | input | 16 | Front-end write data |
| csr_rd | input | 1 | Front-end read strobe |
| csr_rdata | output | 16 | Registered front-end read data |
| be_req | output | 1 | Back-end transfer request |
| be_we | output | 1 | Back-end direction, 1 = write |
| be_ofs | output | 4 | Back-end register offset |
| be_wdata | output | 16 | Back-end write data |
| be_rdata | input | 16 | Back-end read data |
| be_ack | input | 1 | Back-end acknowledge |
| pll_sel | output | 2 | Physical PLL port of the current operation |
| cal_start | output | 1 | One-cycle calibration start pulse |
| cal_done | input | 1 | Calibration converged |
| cal_fail | input | 1 | Calibration failed to converge |

## Verification
The bench builds the bridge with its default parameters: six logical channels, two-bit port numbers and the default map. This table mixes valid and unconnected entries and maps channels out of order, so a lookup by index or by mistake shows up as a wrong `pll_sel`. With six entries, channel 6 is the first number past the table end and is checked as a boundary. The ten-bit channel register also allows numbers far beyond that range.

// File: rtl/pll_tune_pkg.sv
package pll_tune_pkg;
  localparam int CSR_AW = 7;
  localparam int CSR_DW = 16;
  localparam int CH_W   = 10;
  localparam int OFS_W  = 4;
  localparam int DAT_W  = 16;

  localparam logic [CSR_AW-1:0] A_CHAN = 7'h30;
  localparam logic [CSR_AW-1:0] A_CTRL = 7'h32;
  localparam logic [CSR_AW-1:0] A_OFS  = 7'h33;
  localparam logic [CSR_AW-1:0] A_DATA = 7'h34;

  localparam int TRIG_WR  = 0;
  localparam int TRIG_RD  = 1;
  localparam int ST_BUSY  = 8;
  localparam int ST_ERR   = 9;
  localparam int CAL_BIT  = 1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_BUS, SQ_CAL} seq_st_t;
endpackage

// File: rtl/pll_tune_chanmap.sv
module pll_tune_chanmap #(
  parameter int N_LOG  = 6,
  parameter int PORT_W = 2,
  parameter int CH_W   = 10,
  parameter logic [N_LOG*(PORT_W+1)-1:0] MAP_TABLE = '0
) (
  input  logic [CH_W-1:0]   chan,
  output logic              ok,
  output logic [PORT_W-1:0] port
);
  localparam int EW = PORT_W + 1;

  logic              ent_vld  [N_LOG];
  logic [PORT_W-1:0] ent_port [N_LOG];

  for (genvar g = 0; g < N_LOG; g++) begin : g_ent
    assign ent_vld[g]  = MAP_TABLE[g*EW+PORT_W];
    assign ent_port[g] = MAP_TABLE[g*EW +: PORT_W];
  end

  always_comb begin
    ok   = 1'b0;
    port = '0;
    for (int i = 0; i < N_LOG; i++) begin
      if (chan == CH_W'(i)) begin
        ok   = ent_vld[i];
        port = ent_port[i];
      end
    end
  end
endmodule

// File: rtl/pll_tune_seq.sv
module pll_tune_seq
  import pll_tune_pkg::*;
#(
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_wr,
  input  logic              map_ok,
  input  logic [PORT_W-1:0] map_port,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DAT_W-1:0]  wdata,
  input  logic              be_ack,
  input  logic [DAT_W-1:0]  be_rdata,
  input  logic              cal_done,
  input  logic              cal_fail,
  output logic              busy,
  output logic              err,
  output logic              be_req,
  output logic              be_we,
  output logic [OFS_W-1:0]  be_ofs,
  output logic [DAT_W-1:0]  be_wdata,
  output logic [PORT_W-1:0] pll_sel,
  output logic              cal_start,
  output logic              rd_load,
  output logic [DAT_W-1:0]  rd_val,
  output logic              cal_end
);
  seq_st_t st;
  logic    is_cal;
  logic    cal_fin;

  assign is_cal  = go_wr && (ofs == '0) && wdata[CAL_BIT];
  assign cal_fin = cal_done || cal_fail;

  // Combinational hand-off to the register file: the data word updates
  // on the same edge that retires the operation.
  assign rd_load = (st == SQ_BUS) && be_ack && !be_we;
  assign rd_val  = be_rdata;
  assign cal_end = (st == SQ_CAL) && cal_fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      busy      <= 1'b0;
      err       <= 1'b0;
      be_req    <= 1'b0;
      be_we     <= 1'b0;
      be_ofs    <= '0;
      be_wdata  <= '0;
      pll_sel   <= '0;
      cal_start <= 1'b0;
    end else begin
      cal_start <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (go) begin
            if (!map_ok) begin
              err <= 1'b1;
            end else begin
              err      <= 1'b0;
              busy     <= 1'b1;
              pll_sel  <= map_port;
              be_ofs   <= ofs;
              be_wdata <= wdata;
              be_we    <= go_wr;
              if (is_cal) begin
                st        <= SQ_CAL;
                cal_start <= 1'b1;
              end else begin
                st     <= SQ_BUS;
                be_req <= 1'b1;
              end
            end
          end
        end
        SQ_BUS: begin
          if (be_ack) begin
            be_req <= 1'b0;
            busy   <= 1'b0;
            st     <= SQ_IDLE;
          end
        end
        SQ_CAL: begin
          if (cal_fin) begin
            busy <= 1'b0;
            err  <= cal_fail;
            st   <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_tune_bridge.sv
module pll_tune_bridge
  import pll_tune_pkg::*;
#(
  parameter int N_LOG  = 6,
  parameter int PORT_W = 2,
  parameter logic [N_LOG*(PORT_W+1)-1:0] MAP_TABLE = 18'b000_101_000_111_100_110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_wr,
  input  logic [CSR_DW-1:0] csr_wdata,
  input  logic              csr_rd,
  output logic [CSR_DW-1:0] csr_rdata,
  output logic              be_req,
  output logic              be_we,
  output logic [OFS_W-1:0]  be_ofs,
  output logic [DAT_W-1:0]  be_wdata,
  input  logic [DAT_W-1:0]  be_rdata,
  input  logic              be_ack,
  output logic [PORT_W-1:0] pll_sel,
  output logic              cal_start,
  input  logic              cal_done,
  input  logic              cal_fail
);
  logic [CH_W-1:0]   chan_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DAT_W-1:0]  data_q;
  logic              busy_w, err_w;
  logic              map_ok_w;
  logic [PORT_W-1:0] map_port_w;
  logic              cmd_go_w, cmd_wr_w;
  logic              rd_load_w, cal_end_w;
  logic [DAT_W-1:0]  rd_val_w;
  logic              cfg_wr;
  logic [CSR_DW-1:0] rd_mux;

  assign cfg_wr   = csr_wr && !busy_w;
  assign cmd_go_w = csr_wr && (csr_addr == A_CTRL) &&
                    (csr_wdata[TRIG_WR] || csr_wdata[TRIG_RD]);
  assign cmd_wr_w = csr_wdata[TRIG_WR];

  pll_tune_chanmap #(
    .N_LOG(N_LOG), .PORT_W(PORT_W), .CH_W(CH_W), .MAP_TABLE(MAP_TABLE)
  ) u_map (
    .chan(chan_q), .ok(map_ok_w), .port(map_port_w)
  );

  pll_tune_seq #(.PORT_W(PORT_W)) u_seq (
    .clk(clk), .rst(rst),
    .go(cmd_go_w), .go_wr(cmd_wr_w),
    .map_ok(map_ok_w), .map_port(map_port_w),
    .ofs(ofs_q), .wdata(data_q),
    .be_ack(be_ack), .be_rdata(be_rdata),
    .cal_done(cal_done), .cal_fail(cal_fail),
    .busy(busy_w), .err(err_w),
    .be_req(be_req), .be_we(be_we), .be_ofs(be_ofs), .be_wdata(be_wdata),
    .pll_sel(pll_sel), .cal_start(cal_start),
    .rd_load(rd_load_w), .rd_val(rd_val_w), .cal_end(cal_end_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      ofs_q  <= '0;
      data_q <= '0;
    end else begin
      if (cfg_wr && csr_addr == A_CHAN) chan_q <= csr_wdata[CH_W-1:0];
      if (cfg_wr && csr_addr == A_OFS)  ofs_q  <= csr_wdata[OFS_W-1:0];
      if (rd_load_w)
        data_q <= rd_val_w;
      else if (cal_end_w)
        data_q[CAL_BIT] <= 1'b0;
      else if (cfg_wr && csr_addr == A_DATA)
        data_q <= csr_wdata[DAT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (csr_addr)
      A_CHAN: rd_mux[CH_W-1:0]  = chan_q;
      A_OFS:  rd_mux[OFS_W-1:0] = ofs_q;
      A_DATA: rd_mux[DAT_W-1:0] = data_q;
      A_CTRL: begin
        rd_mux[ST_ERR]  = err_w;
        rd_mux[ST_BUSY] = busy_w;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         csr_rdata <= '0;
    else if (csr_rd) csr_rdata <= rd_mux;
  end
endmodule

// File: rtl/pll_tune_bridge_chk.sv
module pll_tune_bridge_chk #(
  parameter int PORT_W = 2,
  parameter int OFS_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              err,
  input logic              map_ok,
  input logic              cmd_go,
  input logic              be_req,
  input logic              be_ack,
  input logic              be_we,
  input logic [OFS_W-1:0]  be_ofs,
  input logic [PORT_W-1:0] pll_sel,
  input logic              cal_start,
  input logic              cal_done,
  input logic              cal_fail
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    be_req && !be_ack |=> be_req && $stable(be_ofs) && $stable(pll_sel) && $stable(be_we));

  assert_req_busy_R5: assert property (@(posedge clk) disable iff (rst)
    be_req |-> busy);

  assert_busy_clear_R5: assert property (@(posedge clk) disable iff (rst)
    be_req && be_ack |=> !busy);

  assert_bad_chan_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_go && !busy && !map_ok |=> err && !busy && !be_req && !cal_start);

  assert_cal_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    cal_start |-> !be_req ##1 !cal_start);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_go && !busy && map_ok |=> !err && busy);

  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy && !be_ack && !cal_done && !cal_fail |=> busy && $stable(be_ofs) && $stable(pll_sel));
endmodule

bind pll_tune_bridge pll_tune_bridge_chk #(.PORT_W(PORT_W), .OFS_W(pll_tune_pkg::OFS_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_w), .err(err_w), .map_ok(map_ok_w),
  .cmd_go(cmd_go_w), .be_req(be_req), .be_ack(be_ack), .be_we(be_we),
  .be_ofs(be_ofs), .pll_sel(pll_sel), .cal_start(cal_start),
  .cal_done(cal_done), .cal_fail(cal_fail)
);

// File: tb/pll_tune_bridge_test.sv
module pll_tune_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  csr_addr = '0;
  logic        csr_wr = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic        csr_rd = 1'b0;
  logic [15:0] csr_rdata;
  logic        be_req, be_we;
  logic [3:0]  be_ofs;
  logic [15:0] be_wdata;
  logic [15:0] be_rdata = '0;
  logic        be_ack = 1'b0;
  logic [1:0]  pll_sel;
  logic        cal_start;
  logic        cal_done = 1'b0;
  logic        cal_fail = 1'b0;

  int n_run = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam logic [6:0] CHAN = 7'h30, CTRL = 7'h32, OFS = 7'h33, DATA = 7'h34;

  pll_tune_bridge uut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
    .be_req(be_req), .be_we(be_we), .be_ofs(be_ofs), .be_wdata(be_wdata),
    .be_rdata(be_rdata), .be_ack(be_ack), .pll_sel(pll_sel),
    .cal_start(cal_start), .cal_done(cal_done), .cal_fail(cal_fail)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk); csr_addr = a; csr_rd = 1'b1;
    @(negedge clk); csr_rd = 1'b0; d = csr_rdata;
  endtask

  task automatic ack(input logic [15:0] v);
    @(negedge clk); be_ack = 1'b1; be_rdata = v;
    @(negedge clk); be_ack = 1'b0; be_rdata = '0;
  endtask

  task automatic cal_end(input bit fail);
    @(negedge clk); cal_done = !fail; cal_fail = fail;
    @(negedge clk); cal_done = 1'b0; cal_fail = 1'b0;
  endtask

  task automatic setup(input logic [9:0] c, input logic [3:0] o, input logic [15:0] d);
    wr(CHAN, {6'b0, c}); wr(OFS, {12'b0, o}); wr(DATA, d);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1", "be_req", be_req, 0);
    chk("R1", "cal_start", cal_start, 0);
    rd(CHAN, v); chk("R1", "chan", v, 0);
    rd(CTRL, v); chk("R1", "status", v, 0);
    rd(OFS, v);  chk("R1", "ofs", v, 0);
    rd(DATA, v); chk("R1", "data", v, 0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(CHAN, 16'hFFFF); rd(CHAN, v); chk("R2", "chan width", v, 16'h03FF);
    wr(OFS, 16'hFFFF);  rd(OFS, v);  chk("R2", "ofs width", v, 16'h000F);
    wr(DATA, 16'hBEEF); rd(DATA, v); chk("R2", "data rw", v, 16'hBEEF);
    rd(7'h31, v); chk("R2", "undefined addr", v, 0);
    rd(CTRL, v);  chk("R2", "status idle", v, 0);
    chk("R2", "no req from cfg", be_req, 0);
  endtask

  task automatic t_write();
    logic [15:0] v;
    setup(10'd0, 4'd5, 16'hA55A);
    wr(CTRL, 16'h0001);
    chk("R3", "req", be_req, 1);
    chk("R3", "we", be_we, 1);
    chk("R12", "port ch0", pll_sel, 2);
    chk("R3", "ofs", be_ofs, 5);
    chk("R3", "wdata", be_wdata, 16'hA55A);
    rd(CTRL, v); chk("R5", "busy during", v, 16'h0100);
    chk("R3", "req held", be_req, 1);
    ack(16'h0000);
    chk("R3", "req drop", be_req, 0);
    rd(CTRL, v); chk("R5", "busy after ack", v, 0);
  endtask

  task automatic t_read();
    logic [15:0] v;
    setup(10'd4, 4'd3, 16'h0000);
    wr(CTRL, 16'h0002);
    chk("R4", "req", be_req, 1);
    chk("R4", "we", be_we, 0);
    chk("R12", "port ch4", pll_sel, 1);
    ack(16'h1234);
    rd(DATA, v); chk("R4", "read data", v, 16'h1234);
    rd(CTRL, v); chk("R5", "idle", v, 0);
  endtask

  task automatic t_bad(input logic [9:0] c, input string tag);
    logic [15:0] v;
    setup(c, 4'd1, 16'h0001);
    wr(CTRL, 16'h0001);
    chk("R6", {tag, " req"}, be_req, 0);
    chk("R6", {tag, " cal"}, cal_start, 0);
    rd(CTRL, v); chk("R6", {tag, " status"}, v, 16'h0200);
    chk("R6", {tag, " req later"}, be_req, 0);
  endtask

  task automatic t_err_clear();
    logic [15:0] v;
    setup(10'd2, 4'd6, 16'h00FF);
    wr(CTRL, 16'h0001);
    chk("R12", "port ch2", pll_sel, 3);
    rd(CTRL, v); chk("R9", "err cleared", v, 16'h0100);
    ack(16'h0000);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    setup(10'd1, 4'd7, 16'h1111);
    wr(CTRL, 16'h0001);
    chk("R12", "port ch1", pll_sel, 0);
    wr(CHAN, 16'h0002); wr(OFS, 16'h0009); wr(DATA, 16'h2222);
    wr(CTRL, 16'h0002);
    chk("R10", "ofs kept", be_ofs, 7);
    chk("R10", "we kept", be_we, 1);
    chk("R10", "port kept", pll_sel, 0);
    ack(16'h0000);
    chk("R10", "no second req", be_req, 0);
    rd(CHAN, v); chk("R10", "chan kept", v, 1);
    rd(OFS, v);  chk("R10", "ofs reg kept", v, 7);
    rd(DATA, v); chk("R10", "data kept", v, 16'h1111);
  endtask

  task automatic t_both();
    setup(10'd0, 4'd2, 16'h0BEE);
    wr(CTRL, 16'h0003);
    chk("R11", "both bits write", be_we, 1);
    chk("R11", "req", be_req, 1);
    ack(16'h0000);
  endtask

  task automatic t_cal(input bit fail);
    logic [15:0] v;
    string tag;
    tag = fail ? "R8" : "R7";
    setup(10'd2, 4'd0, 16'h0402);
    wr(CTRL, 16'h0001);
    chk("R7", "cal_start", cal_start, 1);
    chk("R7", "no req", be_req, 0);
    chk("R7", "cal port", pll_sel, 3);
    @(negedge clk);
    chk("R7", "pulse one cycle", cal_start, 0);
    chk("R7", "still no req", be_req, 0);
    rd(CTRL, v); chk("R5", "busy in cal", v, 16'h0100);
    cal_end(fail);
    rd(CTRL, v); chk(tag, "status after cal", v, fail ? 16'h0200 : 16'h0000);
    rd(DATA, v); chk("R7", "trigger self-clear", v, 16'h0400);
  endtask

  task automatic t_ofs0_plain();
    setup(10'd4, 4'd0, 16'h0001);
    wr(CTRL, 16'h0001);
    chk("R13", "plain req", be_req, 1);
    chk("R13", "no cal", cal_start, 0);
    chk("R13", "ofs", be_ofs, 0);
    ack(16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_write();
    t_read();
    t_bad(10'd3, "unconnected");
    t_err_clear();
    t_bad(10'd6, "past end");
    t_bad(10'd1000, "far beyond");
    t_busy_ignore();
    t_both();
    t_cal(1'b0);
    t_cal(1'b1);
    t_ofs0_plain();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule